// File: doc/BRIEF.md
# Cross-Ring Call and Return Validator

This block checks a transfer of control that may cross protection rings and decides which ring execution continues in. A call or a return strobe presents the caller's current ring, the effective ring and word number of the target, and the target segment's descriptor. The descriptor carries three ring limits: low (L), top of execute (T) and top of the gate extension (G), with L ≤ T ≤ G. It also carries an execute permission bit and a short list of gate word offsets, each with a valid bit. The block also receives the ring fields of the pointer registers.

On a call the block grants the transfer only when the segment is executable, the effective ring lies between L and G, and the target word is a listed gate. A caller in the gate extension (above T) moves down to ring T. A caller inside L..T keeps its ring. A caller below L is making an upward call, which traps. On a return, a target ring below the current ring traps. Otherwise the block lowers privilege by raising every pointer register's ring to at least the target ring. Every result is registered and appears one clock after the strobe, with a done pulse.

Top module: `ring_xfer_unit`

## Requirements
- R1: After reset, done, trap and cause are 0, the new ring is 0 and every pointer ring output is 0.
- R2: Done is 1 in exactly the cycle after a cycle with a call or return strobe. In a cycle after no strobe, done is 0 and new ring, trap, cause and pointer ring outputs hold their values.
- R3: A call to a segment whose execute bit is 0 traps with cause 1, whatever the rings and gates.
- R4: A call from an executable segment with effective ring below L is an upward call and traps with cause 2.
- R5: A call from an executable segment with effective ring above G traps with cause 3.
- R6: A call that passes R3 to R5 but whose target word matches no gate entry with its valid bit set traps with cause 4. An entry with its valid bit clear never matches.
- R7: A granted call with effective ring above T gives new ring T, trap 0 and cause 0.
- R8: A granted call with effective ring within L..T gives new ring equal to the effective ring.
- R9: A return whose target ring is below the current ring traps with cause 5.
- R10: A return whose target ring is at or above the current ring gives new ring equal to the target ring. Each pointer ring output is the larger of its input ring and the target ring.
- R11: On any trap the new ring equals the current ring. On any trap and on every call, the pointer ring outputs equal the pointer ring inputs.
- R12: When call and return strobe together, the call is processed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| cur_ring_i | input | RING_W | Current ring of execution |
| tgt_ring_i | input | RING_W | Effective ring of the transfer |
| tgt_word_i | input | WORD_W | Target word number |
| seg_lo_i | input | RING_W | Descriptor ring limit L |
| seg_top_i | input | RING_W | Descriptor ring limit T |
| seg_gext_i | input | RING_W | Descriptor ring limit G |
| seg_exec_i | input | 1 | Segment execute permission |
| gate_off_i | input | NGATE*WORD_W | Gate word offsets, entry k in bits k*WORD_W upward |
| gate_vld_i | input | NGATE | Valid bit per gate entry |
| ptr_ring_i | input | NPTR*RING_W | Pointer register rings, register k in bits k*RING_W upward |
| done_o | output | 1 | Result valid pulse |
| trap_o | output | 1 | Transfer refused, software must handle |
| cause_o | output | 3 | Trap cause code (0 none, 1..5 per R3-R6, R9) |
| new_ring_o | output | RING_W | Ring of execution after the transfer |
| ptr_ring_o | output | NPTR*RING_W | Updated pointer register rings |

## Verification
The bench builds the block with eight rings, four gate entries, four pointer registers and a 6-bit word number. With a word that narrow, targets drawn at random often hit a listed gate, so granted calls appear often. Invalid entries that hold the target word also appear, which exercises the rule that invalid entries never match. Eight rings with randomly ordered L ≤ T ≤ G limits make every case reachable: upward calls, over-bracket calls, calls from the gate extension, in-bracket calls, and both return directions.

// File: rtl/ring_xfer_unit.sv
module ring_xfer_unit #(
  parameter int RING_W = 3,
  parameter int WORD_W = 8,
  parameter int NGATE  = 4,
  parameter int NPTR   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     call_i,
  input  logic                     ret_i,
  input  logic [RING_W-1:0]        cur_ring_i,
  input  logic [RING_W-1:0]        tgt_ring_i,
  input  logic [WORD_W-1:0]        tgt_word_i,
  input  logic [RING_W-1:0]        seg_lo_i,
  input  logic [RING_W-1:0]        seg_top_i,
  input  logic [RING_W-1:0]        seg_gext_i,
  input  logic                     seg_exec_i,
  input  logic [NGATE*WORD_W-1:0]  gate_off_i,
  input  logic [NGATE-1:0]         gate_vld_i,
  input  logic [NPTR*RING_W-1:0]   ptr_ring_i,
  output logic                     done_o,
  output logic                     trap_o,
  output logic [2:0]               cause_o,
  output logic [RING_W-1:0]        new_ring_o,
  output logic [NPTR*RING_W-1:0]   ptr_ring_o
);

  localparam logic [2:0] C_NONE    = 3'd0;
  localparam logic [2:0] C_NOEXEC  = 3'd1;
  localparam logic [2:0] C_UPCALL  = 3'd2;
  localparam logic [2:0] C_ABOVE   = 3'd3;
  localparam logic [2:0] C_NOGATE  = 3'd4;
  localparam logic [2:0] C_DOWNRET = 3'd5;

  logic [NGATE-1:0]       hit;
  logic [2:0]             call_cause;
  logic [RING_W-1:0]      call_ring;
  logic                   ret_bad;
  logic [NPTR*RING_W-1:0] ptr_raised;

  for (genvar g = 0; g < NGATE; g++) begin : g_gate
    assign hit[g] = gate_vld_i[g] && (gate_off_i[g*WORD_W +: WORD_W] == tgt_word_i);
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    wire [RING_W-1:0] pr = ptr_ring_i[p*RING_W +: RING_W];
    assign ptr_raised[p*RING_W +: RING_W] = (pr > tgt_ring_i) ? pr : tgt_ring_i;
  end

  always_comb begin
    call_cause = C_NONE;
    if (!seg_exec_i)              call_cause = C_NOEXEC;
    else if (tgt_ring_i < seg_lo_i)   call_cause = C_UPCALL;
    else if (tgt_ring_i > seg_gext_i) call_cause = C_ABOVE;
    else if (hit == '0)           call_cause = C_NOGATE;
  end

  assign call_ring = (tgt_ring_i > seg_top_i) ? seg_top_i : tgt_ring_i;
  assign ret_bad   = tgt_ring_i < cur_ring_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      trap_o     <= 1'b0;
      cause_o    <= C_NONE;
      new_ring_o <= '0;
      ptr_ring_o <= '0;
    end else begin
      done_o <= call_i || ret_i;
      if (call_i) begin
        trap_o     <= call_cause != C_NONE;
        cause_o    <= call_cause;
        new_ring_o <= (call_cause != C_NONE) ? cur_ring_i : call_ring;
        ptr_ring_o <= ptr_ring_i;
      end else if (ret_i) begin
        trap_o     <= ret_bad;
        cause_o    <= ret_bad ? C_DOWNRET : C_NONE;
        new_ring_o <= ret_bad ? cur_ring_i : tgt_ring_i;
        ptr_ring_o <= ret_bad ? ptr_ring_i : ptr_raised;
      end
    end
  end

endmodule

// File: rtl/ring_xfer_unit_chk.sv
module ring_xfer_unit_chk #(
  parameter int RING_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_i,
  input logic              ret_i,
  input logic [RING_W-1:0] cur_ring_i,
  input logic [RING_W-1:0] tgt_ring_i,
  input logic [RING_W-1:0] seg_lo_i,
  input logic [RING_W-1:0] seg_top_i,
  input logic              seg_exec_i,
  input logic              done_o,
  input logic              trap_o,
  input logic [2:0]        cause_o,
  input logic [RING_W-1:0] new_ring_o
);

  p_done_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i || ret_i) |=> done_o);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_i || ret_i) |=> (!done_o && $stable(new_ring_o) && $stable(trap_o)));

  p_noexec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !seg_exec_i) |=> (trap_o && cause_o == 3'd1));

  p_upcall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && seg_exec_i && tgt_ring_i < seg_lo_i) |=> (trap_o && cause_o == 3'd2));

  p_granted_in_bracket_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && seg_exec_i && tgt_ring_i >= seg_lo_i) |=>
      (trap_o || (new_ring_o <= $past(seg_top_i) && new_ring_o >= $past(seg_lo_i))));

  p_downret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && tgt_ring_i < cur_ring_i) |=> (trap_o && cause_o == 3'd5));

  p_ret_ring_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && tgt_ring_i >= cur_ring_i) |=> (!trap_o && new_ring_o == $past(tgt_ring_i)));

  p_trap_keeps_ring_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i || ret_i) |=> (!trap_o || new_ring_o == $past(cur_ring_i)));

  p_cause_coherent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (trap_o == (cause_o != 3'd0)));

endmodule

bind ring_xfer_unit ring_xfer_unit_chk #(.RING_W(RING_W)) u_chk (.*);

// File: tb/ring_xfer_unit_bench.sv
module ring_xfer_unit_bench;
  localparam int RW = 3, WW = 6, NG = 4, NP = 4;

  logic clk = 0, rst_n = 0;
  logic call_i = 0, ret_i = 0, seg_exec_i = 0;
  logic [RW-1:0] cur_ring_i = 0, tgt_ring_i = 0, seg_lo_i = 0, seg_top_i = 0, seg_gext_i = 0;
  logic [WW-1:0] tgt_word_i = 0;
  logic [NG*WW-1:0] gate_off_i = 0;
  logic [NG-1:0] gate_vld_i = 0;
  logic [NP*RW-1:0] ptr_ring_i = 0;
  logic done_o, trap_o;
  logic [2:0] cause_o;
  logic [RW-1:0] new_ring_o;
  logic [NP*RW-1:0] ptr_ring_o;

  always #4 clk = ~clk;

  ring_xfer_unit #(.RING_W(RW), .WORD_W(WW), .NGATE(NG), .NPTR(NP)) u_ring_xfer_unit (.*);

  int checks = 0, errors = 0, cycles = 0;
  int e_done = 0, e_trap = 0, e_cause = 0, e_ring = 0;
  int e_ptr[NP];
  string e_tag = "R1", e_ptag = "R1";

  initial for (int k = 0; k < NP; k++) e_ptr[k] = 0;

  always @(posedge clk) begin
    int t, c, lo, top, gx, cause;
    bit gate;
    cycles++;
    if (!rst_n) begin
      e_done = 0; e_trap = 0; e_cause = 0; e_ring = 0; e_tag = "R1"; e_ptag = "R1";
      for (int k = 0; k < NP; k++) e_ptr[k] = 0;
    end else if (!call_i && !ret_i) begin
      e_done = 0; e_tag = "R2"; e_ptag = "R2";
    end else begin
      t = tgt_ring_i; c = cur_ring_i; lo = seg_lo_i; top = seg_top_i; gx = seg_gext_i;
      e_done = 1;
      if (call_i) begin
        gate = 0;
        for (int g = 0; g < NG; g++)
          if (gate_vld_i[g] && gate_off_i[g*WW +: WW] == tgt_word_i) gate = 1;
        if (!seg_exec_i) begin cause = 1; e_tag = "R3"; end
        else if (t < lo) begin cause = 2; e_tag = "R4"; end
        else if (t > gx) begin cause = 3; e_tag = "R5"; end
        else if (!gate)  begin cause = 4; e_tag = "R6"; end
        else begin cause = 0; e_tag = (t > top) ? "R7" : "R8"; end
        if (ret_i) e_tag = "R12";
        e_cause = cause; e_trap = (cause != 0);
        e_ring = (cause != 0) ? c : ((t > top) ? top : t);
        for (int k = 0; k < NP; k++) e_ptr[k] = ptr_ring_i[k*RW +: RW];
        e_ptag = "R11";
      end else if (t < c) begin
        e_cause = 5; e_trap = 1; e_ring = c; e_tag = "R9"; e_ptag = "R11";
        for (int k = 0; k < NP; k++) e_ptr[k] = ptr_ring_i[k*RW +: RW];
      end else begin
        e_cause = 0; e_trap = 0; e_ring = t; e_tag = "R10"; e_ptag = "R10";
        for (int k = 0; k < NP; k++) begin
          e_ptr[k] = ptr_ring_i[k*RW +: RW];
          if (t > e_ptr[k]) e_ptr[k] = t;
        end
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cycles > 0) begin
    chk(e_tag, "done", done_o, e_done);
    chk(e_tag, "trap", trap_o, e_trap);
    chk(e_tag, "cause", cause_o, e_cause);
    chk(e_tag, "new_ring", new_ring_o, e_ring);
    for (int k = 0; k < NP; k++) chk(e_ptag, "ptr_ring", ptr_ring_o[k*RW +: RW], e_ptr[k]);
  end

  task automatic seg(int lo, int top, int gx, bit ex);
    seg_lo_i = lo[RW-1:0]; seg_top_i = top[RW-1:0]; seg_gext_i = gx[RW-1:0]; seg_exec_i = ex;
  endtask

  task automatic xfer(bit c, bit r, int cur, int tgt, int word);
    @(negedge clk);
    call_i = c; ret_i = r; cur_ring_i = cur[RW-1:0]; tgt_ring_i = tgt[RW-1:0];
    tgt_word_i = word[WW-1:0];
    @(negedge clk);
    call_i = 0; ret_i = 0;
  endtask

  initial begin
    gate_off_i = {6'd40, 6'd30, 6'd20, 6'd10};
    gate_vld_i = 4'b0111;
    ptr_ring_i = {3'd6, 3'd1, 3'd4, 3'd2};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    seg(2, 4, 6, 1);
    xfer(1, 0, 5, 5, 20);   // R7 gate extension
    xfer(1, 0, 3, 3, 10);   // R8 in bracket
    xfer(1, 0, 3, 1, 10);   // R4 upward
    xfer(1, 0, 7, 7, 10);   // R5 above
    xfer(1, 0, 3, 3, 40);   // R6 invalid entry
    xfer(1, 0, 3, 3, 11);   // R6 no entry
    xfer(1, 0, 4, 4, 30);   // R8 top
    xfer(1, 0, 6, 6, 30);   // R7 top of extension
    xfer(1, 0, 2, 2, 20);   // R8 bottom
    seg(2, 4, 6, 0);
    xfer(1, 0, 3, 3, 10);   // R3
    xfer(1, 1, 3, 3, 10);   // R12
    xfer(0, 1, 4, 2, 0);    // R9
    xfer(0, 1, 2, 5, 0);    // R10
    xfer(0, 1, 3, 3, 0);    // R10 equal
    seg(2, 4, 6, 1);
    xfer(1, 1, 5, 5, 20);   // R12 granted call wins
    for (int i = 0; i < 3000; i++) begin
      int a, b, c3;
      @(negedge clk);
      a = $urandom_range(0, 7); b = $urandom_range(0, 7); c3 = $urandom_range(0, 7);
      if (a > b) begin int s = a; a = b; b = s; end
      if (b > c3) begin int s = b; b = c3; c3 = s; end
      if (a > b) begin int s = a; a = b; b = s; end
      seg(a, b, c3, $urandom_range(0, 7) != 0);
      gate_off_i = NG*WW'($urandom);
      gate_vld_i = NG'($urandom);
      ptr_ring_i = NP*RW'($urandom);
      cur_ring_i = RW'($urandom); tgt_ring_i = RW'($urandom);
      tgt_word_i = ($urandom_range(0, 1) == 1) ? gate_off_i[$urandom_range(0, NG-1)*WW +: WW] : WW'($urandom);
      call_i = ($urandom_range(0, 2) == 0); ret_i = ($urandom_range(0, 2) == 0);
    end
    @(negedge clk); call_i = 0; ret_i = 0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule